// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block produces the driver-enable signal for an external half-duplex line transceiver, such as an RS-485 driver, from the state of a serial transmitter. It watches three things from the transmitter: a one-cycle pulse when a byte is accepted for sending, the empty status of the transmit queue and of the shift register, and a pulse that marks the end of a stop bit. A feature-enable bit from the control register file selects automatic operation. When that bit is clear, the pin simply mirrors the ordinary modem-control request-to-send bit.

In automatic mode the pin moves to transmit as soon as a byte is loaded. It returns to receive only when a stop bit ends while the queue and the shift register are both empty, which means the last queued character has fully left the line. Bytes that arrive back to back keep the pin in transmit with no pulse to receive between them. The pin is low for transmit and high for receive. It comes from a flop, so it cannot glitch.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, `dir_n` is high (receive) and the transmit tracker is idle.
- R2: With `auto_en` high, a `tx_load` pulse sampled at a clock edge drives `dir_n` low (transmit) from that same edge.
- R3: With `auto_en` high and the tracker busy, `dir_n` stays low on every cycle in which no qualified end of stop bit is seen.
- R4: With `auto_en` high and the tracker busy, `stop_end` together with `fifo_empty` high and `shift_empty` high (and no `tx_load`) drives `dir_n` high from that edge.
- R5: A `stop_end` pulse while `fifo_empty` or `shift_empty` is low does not end the transmission, and `dir_n` stays low.
- R6: A `tx_load` in the same cycle as a qualified end of stop bit keeps the tracker busy, so `dir_n` stays low with no receive pulse.
- R7: With `auto_en` low, `dir_n` equals the inverse of `man_rts`, with one cycle of latency.
- R8: The tracker follows loads and drains while `auto_en` is low, so enabling it in the middle of a transfer gives transmit at once.
- R9: A `stop_end` pulse while the tracker is idle has no effect, and `dir_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| auto_en | input | 1 | Automatic direction control enable (feature control bit 3) |
| man_rts | input | 1 | Modem-control request-to-send bit, used when automatic mode is off |
| tx_load | input | 1 | One-cycle pulse: a byte was accepted for transmission |
| fifo_empty | input | 1 | Transmit queue / holding register is empty |
| shift_empty | input | 1 | Transmit shift register is empty |
| stop_end | input | 1 | One-cycle pulse at the end of a stop bit |
| dir_n | output | 1 | Registered direction pin: 0 = transmit, 1 = receive |

## Verification
The controller is driven with single characters, back-to-back characters where a new load lands on the final stop-bit edge, and stop-bit pulses that arrive while only one of the two empty flags is set. Each of these tells apart a controller that checks the full drain condition from one that reacts to a partial one. Further runs toggle `man_rts` with automatic mode off and switch the enable in the middle of a transfer, which shows whether the tracker keeps running underneath the manual path. Stray stop-bit pulses while idle show that the receive state does not react to them.

// File: rtl/hdx_dir_pkg.sv
package hdx_dir_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // Pin level that means "driving the line".
  localparam logic PIN_LVL_TX = 1'b0;
  localparam logic PIN_LVL_RX = ~PIN_LVL_TX;

endpackage

// File: rtl/hdx_rst_sync.sv
module hdx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nx = 1'b1;
    end else begin : g_many
      always_comb chain_nx = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hdx_drain_detect.sv
module hdx_drain_detect #(
  parameter bit NEED_FIFO_EMPTY = 1'b1
) (
  input  logic stop_end,
  input  logic fifo_empty,
  input  logic shift_empty,
  output logic drain_done
);

  // A stop bit ends the burst only when nothing else is waiting behind it.
  generate
    if (NEED_FIFO_EMPTY) begin : g_full
      always_comb drain_done = stop_end & fifo_empty & shift_empty;
    end else begin : g_shift_only
      logic unused_fifo;
      always_comb unused_fifo = fifo_empty;
      always_comb drain_done  = stop_end & shift_empty;
    end
  endgenerate

endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
  import hdx_dir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_load,
  input  logic drain_done,
  output dir_e dir_nx
);

  dir_e dir_q;

  // Next-state: a new load always wins over a drain in the same cycle.
  always_comb begin
    dir_nx = dir_q;
    unique case (dir_q)
      DIR_RX: if (tx_load) dir_nx = DIR_TX;
      DIR_TX: if (!tx_load && drain_done) dir_nx = DIR_RX;
      default: dir_nx = DIR_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= DIR_RX;
    else        dir_q <= dir_nx;
  end

endmodule

// File: rtl/hdx_pin_drive.sv
module hdx_pin_drive
  import hdx_dir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic man_rts,
  input  dir_e dir_nx,
  output logic pin_q
);

  logic pin_nx;

  always_comb begin
    if (auto_en) pin_nx = (dir_nx == DIR_TX) ? PIN_LVL_TX : PIN_LVL_RX;
    else         pin_nx = ~man_rts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= PIN_LVL_RX;
    else        pin_q <= pin_nx;
  end

endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
  import hdx_dir_pkg::*;
#(
  parameter int unsigned RST_STAGES      = 2,
  parameter bit          NEED_FIFO_EMPTY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic man_rts,
  input  logic tx_load,
  input  logic fifo_empty,
  input  logic shift_empty,
  input  logic stop_end,
  output logic dir_n
);

  logic rst_i_n;
  logic drain_done;
  dir_e dir_nx;

  hdx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  hdx_drain_detect #(.NEED_FIFO_EMPTY(NEED_FIFO_EMPTY)) u_drain (
    .stop_end    (stop_end),
    .fifo_empty  (fifo_empty),
    .shift_empty (shift_empty),
    .drain_done  (drain_done)
  );

  hdx_dir_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tx_load    (tx_load),
    .drain_done (drain_done),
    .dir_nx     (dir_nx)
  );

  hdx_pin_drive u_pin (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .auto_en (auto_en),
    .man_rts (man_rts),
    .dir_nx  (dir_nx),
    .pin_q   (dir_n)
  );

endmodule

// File: rtl/hdx_dir_ctrl_chk.sv
module hdx_dir_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic man_rts,
  input logic tx_load,
  input logic fifo_empty,
  input logic shift_empty,
  input logic stop_end,
  input logic dir_n
);

  logic qual_end;
  assign qual_end = stop_end & fifo_empty & shift_empty;

  assert_reset_rx_R1: assert property (@(posedge clk)
    !rst_n |=> dir_n);

  assert_load_to_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && tx_load) |=> !dir_n);

  assert_hold_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $past(auto_en) && !dir_n && !qual_end) |=> !dir_n);

  assert_drain_to_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && qual_end && !tx_load) |=> dir_n);

  assert_manual_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (dir_n == !$past(man_rts)));

  assert_idle_stays_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && $past(auto_en) && dir_n && !tx_load) |=> dir_n);

endmodule

bind hdx_dir_ctrl hdx_dir_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .auto_en     (auto_en),
  .man_rts     (man_rts),
  .tx_load     (tx_load),
  .fifo_empty  (fifo_empty),
  .shift_empty (shift_empty),
  .stop_end    (stop_end),
  .dir_n       (dir_n)
);

// File: tb/hdx_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module hdx_dir_ctrl_tb_top;

  localparam int SYNC_STAGES = 2;

  logic clk;
  logic rst_n;
  logic auto_en, man_rts, tx_load, fifo_empty, shift_empty, stop_end;
  logic dir_n;

  int checks;
  int failures;
  string cur_req;

  // reference model state
  bit ref_busy;
  bit ref_pin;
  int rel_cnt;

  hdx_dir_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .man_rts     (man_rts),
    .tx_load     (tx_load),
    .fifo_empty  (fifo_empty),
    .shift_empty (shift_empty),
    .stop_end    (stop_end),
    .dir_n       (dir_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: a busy flag and the expected pin level.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_busy <= 1'b0;
      ref_pin  <= 1'b1;
      rel_cnt  <= 0;
    end else begin
      if (rel_cnt >= SYNC_STAGES) begin
        bit nb;
        nb = ref_busy;
        if (tx_load) nb = 1'b1;
        else if (ref_busy && stop_end && fifo_empty && shift_empty) nb = 1'b0;
        ref_busy <= nb;
        ref_pin  <= auto_en ? !nb : !man_rts;
      end
      if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s dir_n actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one clock and compare against the model away from the edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, dir_n, ref_pin);
  endtask

  task automatic idle_inputs();
    auto_en = 0; man_rts = 0; tx_load = 0;
    fifo_empty = 1; shift_empty = 1; stop_end = 0;
  endtask

  task automatic load_pulse();
    tx_load = 1; tick(); tx_load = 0;
  endtask

  initial begin
    checks = 0; failures = 0;
    idle_inputs();
    rst_n = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", dir_n, 1'b1);
    rst_n = 1;
    repeat (4) tick();
    chk("R1", dir_n, 1'b1);

    // manual path
    cur_req = "R7";
    man_rts = 1; tick(); chk("R7", dir_n, 1'b0);
    man_rts = 0; tick(); chk("R7", dir_n, 1'b1);
    man_rts = 1; tick(); chk("R7", dir_n, 1'b0);
    man_rts = 0; tick();

    // stray stop bit while idle in automatic mode
    cur_req = "R9";
    auto_en = 1; tick();
    stop_end = 1; tick(); stop_end = 0; chk("R9", dir_n, 1'b1);

    // single character
    cur_req = "R2";
    fifo_empty = 1; shift_empty = 0;
    load_pulse(); chk("R2", dir_n, 1'b0);
    cur_req = "R3";
    repeat (5) tick();
    chk("R3", dir_n, 1'b0);
    cur_req = "R5";
    stop_end = 1; fifo_empty = 0; shift_empty = 1; tick(); chk("R5", dir_n, 1'b0);
    fifo_empty = 1; shift_empty = 0; tick(); chk("R5", dir_n, 1'b0);
    stop_end = 0; shift_empty = 1; tick(); chk("R3", dir_n, 1'b0);
    cur_req = "R4";
    stop_end = 1; tick(); stop_end = 0; chk("R4", dir_n, 1'b1);
    tick(); chk("R9", dir_n, 1'b1);

    // back-to-back: new load on the final stop-bit edge
    cur_req = "R6";
    shift_empty = 0; load_pulse();
    repeat (3) tick();
    shift_empty = 1; stop_end = 1; tx_load = 1;
    tick(); chk("R6", dir_n, 1'b0);
    tx_load = 0; stop_end = 0; shift_empty = 0;
    repeat (3) tick(); chk("R6", dir_n, 1'b0);
    shift_empty = 1; stop_end = 1; tick(); stop_end = 0; chk("R4", dir_n, 1'b1);

    // tracker keeps running while disabled
    cur_req = "R8";
    auto_en = 0; man_rts = 0; tick(); chk("R7", dir_n, 1'b1);
    shift_empty = 0; load_pulse(); chk("R8", dir_n, 1'b1);
    tick();
    auto_en = 1; tick(); chk("R8", dir_n, 1'b0);
    auto_en = 0; man_rts = 1; tick(); chk("R7", dir_n, 1'b0);
    shift_empty = 1; stop_end = 1; tick(); stop_end = 0;
    man_rts = 0; tick();
    auto_en = 1; tick(); chk("R8", dir_n, 1'b1);

    // burst of loads then drain
    cur_req = "R3";
    shift_empty = 0; fifo_empty = 0;
    for (int i = 0; i < 4; i++) begin
      load_pulse();
      stop_end = 1; tick(); stop_end = 0;
      chk("R3", dir_n, 1'b0);
    end
    fifo_empty = 1; shift_empty = 1;
    cur_req = "R4";
    stop_end = 1; tick(); stop_end = 0; chk("R4", dir_n, 1'b1);
    repeat (3) tick();

    // reset in the middle of a transfer
    cur_req = "R1";
    shift_empty = 0; load_pulse();
    rst_n = 0; #1; chk("R1", dir_n, 1'b1);
    idle_inputs();
    @(negedge clk); rst_n = 1;
    repeat (4) tick();
    chk("R1", dir_n, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule